// File: doc/BRIEF.md
# Two-Phase Debug Scan Access Port

This block gives an external debug host serial access to the architectural state of a 32-bit datapath. It holds a 32-bit scan chain that is stepped by two separately pulsed phase inputs rather than by a shift enable. It also holds a bank of addressable 32-bit state registers and a one-bit carry flag. The host sends a read strobe to copy an addressed register into the chain, or a write strobe to copy the chain into an addressed register. A value that has been read is then stepped out serially.

The phase inputs, strobes and serial input are asynchronous to the system clock. They pass through a synchronizer, and each rising edge of a phase input or strobe produces exactly one action.

A hold input freezes the simple normal-mode load path while debug transfers take place. One register holds a field descriptor. Only its upper bits are stored, and its low bits always read as zero.

Top module: `dbg_scan_port`

## Requirements
- R1: After reset, every state register, the carry flag and the scan chain are zero, and `scan_out_o` is 0.
- R2: A rising edge of `ph_b_i` captures `scan_in_i`. A following rising edge of `ph_a_i` shifts the chain one place toward bit 31 and puts the captured bit into bit 0. `scan_out_o` always shows chain bit 31. Thirty-two B/A steps replace the whole chain. The old contents come out bit 31 first, and the first bit sent in ends up in bit 31.
- R3: A rising edge of `ph_a_i` with no rising edge of `ph_b_i` since the previous A edge leaves the chain unchanged.
- R4: A rising edge of `wr_stb_i` copies the chain into the register selected by `addr_i`. Addresses 0 to 10 are data registers, and register k appears at `state_flat_o[32*k +: 32]`.
- R5: A rising edge of `rd_stb_i` copies the register selected by `addr_i` into the chain.
- R6: The register at address 6 stores only bits 31 to 19. Its bits 18 to 0 always read as zero, whatever was written.
- R7: Address 15 is the carry flag. A write takes chain bit 31 into the flag. A read loads the flag into chain bit 31 and zeros into bits 30 to 0.
- R8: Addresses 11 to 14 are unmapped. A read from them loads all zeros into the chain, and a write to them changes no register and not the carry flag.
- R9: A read edge that comes while the synchronized write strobe is high is ignored. When both strobes rise together, only the write takes effect.
- R10: While `hold_i` is high, `norm_we_i` has no effect. While `hold_i` is low, `norm_we_i` loads `norm_data_i` into the register at `norm_addr_i`. The carry flag takes bit 31, and address 6 keeps only bits 31 to 19. A debug write in the same cycle wins.
- R11: A strobe held high acts once, at its rising edge. Shifting while the write strobe stays high does not change the register that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| hold_i | input | 1 | Freezes normal-mode loads |
| ph_a_i | input | 1 | Shift phase A (asynchronous) |
| ph_b_i | input | 1 | Shift phase B (asynchronous) |
| rd_stb_i | input | 1 | Register-to-chain transfer strobe |
| wr_stb_i | input | 1 | Chain-to-register transfer strobe |
| addr_i | input | 4 | Transfer register address |
| scan_in_i | input | 1 | Serial data into chain bit 0 |
| scan_out_o | output | 1 | Chain bit 31 |
| norm_we_i | input | 1 | Normal-mode load enable |
| norm_addr_i | input | 4 | Normal-mode load address |
| norm_data_i | input | 32 | Normal-mode load data |
| state_flat_o | output | 352 | All 11 data registers, register k at 32*k |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the block with its default parameters. These are a 32-bit chain, eleven data registers, the carry flag at address 15, a 13-bit stored field descriptor and a two-stage synchronizer. With these values the unmapped gap from 11 to 14 and the field-descriptor masking can be reached, and the carry's mapping to the top chain bit can be observed directly. The slow strobe and phase pulses span several clock cycles, so the bench can exercise the edge-only behaviour, strobe priority and an A pulse with no B pulse at the ports.

// File: rtl/dbg_scan_pkg.sv
package dbg_scan_pkg;
   // Kind of transfer accepted in a given cycle
   typedef enum logic [1:0] {
      XFER_NONE  = 2'd0,
      XFER_WRITE = 2'd1,
      XFER_READ  = 2'd2
   } xfer_e;

   // Index of each synchronized control line
   localparam int unsigned CTL_PH_A = 0;
   localparam int unsigned CTL_PH_B = 1;
   localparam int unsigned CTL_RD   = 2;
   localparam int unsigned CTL_WR   = 3;
   localparam int unsigned CTL_SER  = 4;
   localparam int unsigned CTL_NUM  = 5;
   localparam int unsigned CTL_EDGES = 4;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/dbg_scan_chain.sv
module dbg_scan_chain #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              b_evt_i,
   input  logic              a_evt_i,
   input  logic              ser_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] load_data_i,
   output logic [DATA_W-1:0] chain_o,
   output logic              ser_o
);
   localparam int unsigned TOP = DATA_W - 1;

   logic [DATA_W-1:0] chain_q;
   logic              bit_q;
   logic              armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         bit_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         // A step consumes the captured bit; B arms the next step
         if (a_evt_i) armed_q <= 1'b0;
         if (b_evt_i) begin
            bit_q   <= ser_i;
            armed_q <= 1'b1;
         end
         // parallel transfer wins over a shift step in the same cycle
         if (load_i) begin
            chain_q <= load_data_i;
         end else if (a_evt_i && armed_q) begin
            chain_q <= {chain_q[TOP-1:0], bit_q};
         end
      end
   end

   assign chain_o = chain_q;
   assign ser_o   = chain_q[TOP];
endmodule

// File: rtl/dbg_state_bank.sv
module dbg_state_bank #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_DATA   = 11,
   parameter int unsigned FIELD_ADDR = 6,
   parameter int unsigned FIELD_KEEP = 13,
   parameter int unsigned CARRY_ADDR = 15
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dbg_we_i,
   input  logic [ADDR_W-1:0]            dbg_addr_i,
   input  logic [DATA_W-1:0]            dbg_data_i,
   input  logic                         norm_we_i,
   input  logic [ADDR_W-1:0]            norm_addr_i,
   input  logic [DATA_W-1:0]            norm_data_i,
   output logic [DATA_W-1:0]            rd_data_o,
   output logic [NUM_DATA*DATA_W-1:0]   state_flat_o,
   output logic                         carry_o
);
   localparam int unsigned TOP      = DATA_W - 1;
   localparam int unsigned DROP_W   = DATA_W - FIELD_KEEP;
   localparam logic [ADDR_W-1:0] CARRY_A = ADDR_W'(CARRY_ADDR);

   logic [DATA_W-1:0] regs_w [NUM_DATA];
   logic              carry_q;

   for (genvar k = 0; k < NUM_DATA; k++) begin : g_reg
      localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(k);
      logic dbg_hit, norm_hit;
      assign dbg_hit  = dbg_we_i  && (dbg_addr_i  == MY_A);
      assign norm_hit = norm_we_i && (norm_addr_i == MY_A);

      if (k == FIELD_ADDR) begin : g_field
         // only the descriptor's upper bits are stored
         logic [FIELD_KEEP-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (dbg_hit)  q <= dbg_data_i[TOP -: FIELD_KEEP];
            else if (norm_hit) q <= norm_data_i[TOP -: FIELD_KEEP];
         end
         assign regs_w[k] = {q, {DROP_W{1'b0}}};
      end else begin : g_full
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= '0;
            else if (dbg_hit)  q <= dbg_data_i;
            else if (norm_hit) q <= norm_data_i;
         end
         assign regs_w[k] = q;
      end

      assign state_flat_o[k*DATA_W +: DATA_W] = regs_w[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        carry_q <= 1'b0;
      else if (dbg_we_i && (dbg_addr_i == CARRY_A))      carry_q <= dbg_data_i[TOP];
      else if (norm_we_i && (norm_addr_i == CARRY_A))    carry_q <= norm_data_i[TOP];
   end

   // unmapped addresses fall through to zero
   always_comb begin
      rd_data_o = '0;
      for (int k = 0; k < NUM_DATA; k++) begin
         if (dbg_addr_i == ADDR_W'(k)) rd_data_o = regs_w[k];
      end
      if (dbg_addr_i == CARRY_A) rd_data_o = {carry_q, {TOP{1'b0}}};
   end

   assign carry_o = carry_q;
endmodule

// File: rtl/dbg_scan_port.sv
module dbg_scan_port #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned NUM_DATA    = 11,
   parameter int unsigned FIELD_ADDR  = 6,
   parameter int unsigned FIELD_KEEP  = 13,
   parameter int unsigned CARRY_ADDR  = 15,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       hold_i,
   input  logic                       ph_a_i,
   input  logic                       ph_b_i,
   input  logic                       rd_stb_i,
   input  logic                       wr_stb_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic                       scan_in_i,
   output logic                       scan_out_o,
   input  logic                       norm_we_i,
   input  logic [ADDR_W-1:0]          norm_addr_i,
   input  logic [DATA_W-1:0]          norm_data_i,
   output logic [NUM_DATA*DATA_W-1:0] state_flat_o,
   output logic                       carry_o
);
   import dbg_scan_pkg::*;

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CARRY_ADDR >= ADDR_SPAN || CARRY_ADDR < NUM_DATA) begin : g_bad_carry
      $error("CARRY_ADDR must lie above the data registers and inside the address space");
   end
   if (FIELD_ADDR >= NUM_DATA) begin : g_bad_field
      $error("FIELD_ADDR must name a data register");
   end
   if (FIELD_KEEP < 1 || FIELD_KEEP >= DATA_W) begin : g_bad_keep
      $error("FIELD_KEEP must be between 1 and DATA_W-1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   logic [CTL_NUM-1:0]   raw_ctl, sync_ctl;
   logic [CTL_EDGES-1:0] prev_q, rise;
   logic                 a_rise, b_rise, rd_rise, wr_rise, wr_lvl, ser_sync;
   logic                 rd_acc, wr_acc, norm_act;
   xfer_e                xfer;
   logic [DATA_W-1:0]    chain, rd_data;

   always_comb begin
      raw_ctl           = '0;
      raw_ctl[CTL_PH_A] = ph_a_i;
      raw_ctl[CTL_PH_B] = ph_b_i;
      raw_ctl[CTL_RD]   = rd_stb_i;
      raw_ctl[CTL_WR]   = wr_stb_i;
      raw_ctl[CTL_SER]  = scan_in_i;
   end

   dbg_sync #(.WIDTH(CTL_NUM), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_ctl),
      .q_o   (sync_ctl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_ctl[CTL_EDGES-1:0];
   end

   assign rise     = sync_ctl[CTL_EDGES-1:0] & ~prev_q;
   assign a_rise   = rise[CTL_PH_A];
   assign b_rise   = rise[CTL_PH_B];
   assign rd_rise  = rise[CTL_RD];
   assign wr_rise  = rise[CTL_WR];
   assign wr_lvl   = sync_ctl[CTL_WR];
   assign ser_sync = sync_ctl[CTL_SER];

   // write edge always wins; a read is dropped while write is high
   always_comb begin
      if (wr_rise)                 xfer = XFER_WRITE;
      else if (rd_rise && !wr_lvl) xfer = XFER_READ;
      else                         xfer = XFER_NONE;
   end
   assign wr_acc   = (xfer == XFER_WRITE);
   assign rd_acc   = (xfer == XFER_READ);
   assign norm_act = norm_we_i && !hold_i;

   dbg_scan_chain #(.DATA_W(DATA_W)) u_chain (
      .clk         (clk),
      .rst_n       (rst_n),
      .b_evt_i     (b_rise),
      .a_evt_i     (a_rise),
      .ser_i       (ser_sync),
      .load_i      (rd_acc),
      .load_data_i (rd_data),
      .chain_o     (chain),
      .ser_o       (scan_out_o)
   );

   dbg_state_bank #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .NUM_DATA   (NUM_DATA),
      .FIELD_ADDR (FIELD_ADDR),
      .FIELD_KEEP (FIELD_KEEP),
      .CARRY_ADDR (CARRY_ADDR)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .dbg_we_i     (wr_acc),
      .dbg_addr_i   (addr_i),
      .dbg_data_i   (chain),
      .norm_we_i    (norm_act),
      .norm_addr_i  (norm_addr_i),
      .norm_data_i  (norm_data_i),
      .rd_data_o    (rd_data),
      .state_flat_o (state_flat_o),
      .carry_o      (carry_o)
   );
endmodule

// File: rtl/dbg_scan_port_chk.sv
module dbg_scan_port_chk #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned NUM_DATA   = 11,
   parameter int unsigned FIELD_ADDR = 6,
   parameter int unsigned FIELD_KEEP = 13,
   parameter int unsigned CARRY_ADDR = 15
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       hold_i,
   input logic                       a_rise,
   input logic                       rd_rise,
   input logic                       rd_acc,
   input logic                       wr_acc,
   input logic                       wr_lvl,
   input logic                       norm_we_i,
   input logic [ADDR_W-1:0]          addr_i,
   input logic [DATA_W-1:0]          chain,
   input logic [NUM_DATA*DATA_W-1:0] state_flat_o,
   input logic                       carry_o
);
   localparam int unsigned DROP_W = DATA_W - FIELD_KEEP;
   localparam int unsigned TOP    = DATA_W - 1;

   logic unmapped;
   assign unmapped = (addr_i >= ADDR_W'(NUM_DATA)) && (addr_i != ADDR_W'(CARRY_ADDR));

   // R6
   field_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state_flat_o[FIELD_ADDR*DATA_W +: DROP_W] == '0);

   // R8
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && unmapped && !(norm_we_i && !hold_i)) |=> ($stable(state_flat_o) && $stable(carry_o)));

   // R8
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && unmapped) |=> (chain == '0));

   // R7
   carry_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && addr_i == ADDR_W'(CARRY_ADDR)) |=> (chain[TOP-1:0] == '0 && chain[TOP] == $past(carry_o)));

   // R10
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_i && !wr_acc) |=> ($stable(state_flat_o) && $stable(carry_o)));

   // R9
   read_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rise && wr_lvl && !a_rise) |=> $stable(chain));

   // R2
   shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rise && !rd_acc) |=> ($stable(chain) || chain[TOP:1] == $past(chain[TOP-1:0])));
endmodule

bind dbg_scan_port dbg_scan_port_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .NUM_DATA   (NUM_DATA),
   .FIELD_ADDR (FIELD_ADDR),
   .FIELD_KEEP (FIELD_KEEP),
   .CARRY_ADDR (CARRY_ADDR)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hold_i       (hold_i),
   .a_rise       (a_rise),
   .rd_rise      (rd_rise),
   .rd_acc       (rd_acc),
   .wr_acc       (wr_acc),
   .wr_lvl       (wr_lvl),
   .norm_we_i    (norm_we_i),
   .addr_i       (addr_i),
   .chain        (chain),
   .state_flat_o (state_flat_o),
   .carry_o      (carry_o)
);

// File: tb/dbg_scan_port_tb.sv
module dbg_scan_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 32;
   localparam int ND = 11;
   localparam int SETTLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold = 1'b1;
   logic ph_a = 1'b0, ph_b = 1'b0, rd = 1'b0, wr = 1'b0, sin = 1'b0;
   logic [3:0] addr = '0;
   logic norm_we = 1'b0;
   logic [3:0] norm_addr = '0;
   logic [W-1:0] norm_data = '0;
   logic scan_out;
   logic [ND*W-1:0] flat;
   logic carry;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_scan_port dut_i (
      .clk (clk), .rst_n (rst_n), .hold_i (hold),
      .ph_a_i (ph_a), .ph_b_i (ph_b), .rd_stb_i (rd), .wr_stb_i (wr),
      .addr_i (addr), .scan_in_i (sin), .scan_out_o (scan_out),
      .norm_we_i (norm_we), .norm_addr_i (norm_addr), .norm_data_i (norm_data),
      .state_flat_o (flat), .carry_o (carry)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [W-1:0] reg_of(input int k);
      return flat[k*W +: W];
   endfunction

   // shift a full word in, returning the bits that came out
   task automatic shift_word(input logic [W-1:0] nv, output logic [W-1:0] ov);
      ov = '0;
      for (int i = 0; i < W; i++) begin
         sin = nv[W-1-i];
         wait_n(SETTLE);
         ph_b = 1'b1;
         wait_n(SETTLE);
         ov[W-1-i] = scan_out;
         ph_b = 1'b0;
         wait_n(SETTLE);
         ph_a = 1'b1;
         wait_n(SETTLE);
         ph_a = 1'b0;
      end
      wait_n(SETTLE);
   endtask

   task automatic xfer(input logic do_rd, input logic do_wr, input logic [3:0] a);
      addr = a;
      wait_n(1);
      rd = do_rd;
      wr = do_wr;
      wait_n(SETTLE);
      rd = 1'b0;
      wr = 1'b0;
      wait_n(SETTLE);
   endtask

   task automatic t_reset;
      logic [W-1:0] o;
      check("R1 scan_out", {31'd0, scan_out}, '0);
      check("R1 carry", {31'd0, carry}, '0);
      for (int k = 0; k < ND; k++) check("R1 reg", reg_of(k), '0);
      shift_word(32'hA5A5_A5A5, o);
      check("R1 chain", o, '0);
   endtask

   task automatic t_shift;
      logic [W-1:0] o;
      shift_word(32'h1234_5678, o);
      check("R2 shift-out order", o, 32'hA5A5_A5A5);
      shift_word(32'h8000_0001, o);
      check("R2 shift-in order", o, 32'h1234_5678);
   endtask

   task automatic t_write_all;
      logic [W-1:0] o, v;
      for (int k = 0; k < ND; k++) begin
         v = 32'hC0DE_0000 | (k * 32'h0000_1111) | 32'h0007_0000;
         shift_word(v, o);
         xfer(1'b0, 1'b1, 4'(k));
      end
      for (int k = 0; k < ND; k++) begin
         v = 32'hC0DE_0000 | (k * 32'h0000_1111) | 32'h0007_0000;
         if (k == 6) check("R6 masked write", reg_of(k), v & 32'hFFF8_0000);
         else        check("R4 write", reg_of(k), v);
      end
   endtask

   task automatic t_read;
      logic [W-1:0] o;
      xfer(1'b1, 1'b0, 4'd3);
      shift_word('0, o);
      check("R5 read", o, 32'hC0DE_0000 | (3 * 32'h0000_1111) | 32'h0007_0000);
   endtask

   task automatic t_field;
      logic [W-1:0] o;
      shift_word(32'hFFFF_FFFF, o);
      xfer(1'b0, 1'b1, 4'd6);
      check("R6 field stored", reg_of(6), 32'hFFF8_0000);
      xfer(1'b1, 1'b0, 4'd6);
      shift_word('0, o);
      check("R6 field readback", o, 32'hFFF8_0000);
   endtask

   task automatic t_carry;
      logic [W-1:0] o;
      shift_word(32'h8000_0000, o);
      xfer(1'b0, 1'b1, 4'd15);
      check("R7 carry set", {31'd0, carry}, 32'd1);
      shift_word(32'h5555_5555, o);
      xfer(1'b1, 1'b0, 4'd15);
      shift_word('0, o);
      check("R7 carry read", o, 32'h8000_0000);
      shift_word(32'h7FFF_FFFF, o);
      xfer(1'b0, 1'b1, 4'd15);
      check("R7 carry clear", {31'd0, carry}, '0);
   endtask

   task automatic t_unmapped;
      logic [W-1:0] o;
      logic [ND*W-1:0] snap;
      logic snap_c;
      snap = flat;
      snap_c = carry;
      shift_word(32'hDEAD_BEEF, o);
      xfer(1'b0, 1'b1, 4'd12);
      total++;
      if (flat !== snap || carry !== snap_c) begin
         bad++;
         $display("FAIL R8 unmapped write act=%h exp=%h", flat[W-1:0], snap[W-1:0]);
      end
      xfer(1'b1, 1'b0, 4'd13);
      shift_word('0, o);
      check("R8 unmapped read", o, '0);
   endtask

   task automatic t_both;
      logic [W-1:0] o;
      shift_word(32'h0BAD_F00D, o);
      xfer(1'b1, 1'b1, 4'd2);
      check("R9 write wins", reg_of(2), 32'h0BAD_F00D);
      shift_word('0, o);
      check("R9 read ignored", o, 32'h0BAD_F00D);
   endtask

   task automatic t_lone_a;
      logic [W-1:0] o;
      shift_word(32'h3C3C_0FF1, o);
      ph_a = 1'b1;
      wait_n(SETTLE);
      ph_a = 1'b0;
      wait_n(SETTLE);
      ph_a = 1'b1;
      wait_n(SETTLE);
      ph_a = 1'b0;
      wait_n(SETTLE);
      shift_word('0, o);
      check("R3 lone A", o, 32'h3C3C_0FF1);
   endtask

   task automatic t_hold;
      norm_addr = 4'd1;
      norm_data = 32'hFEED_0001;
      norm_we = 1'b1;
      wait_n(3);
      norm_we = 1'b0;
      wait_n(1);
      check("R10 hold blocks", reg_of(1), 32'hC0DE_0000 | 32'h0000_1111 | 32'h0007_0000);
      hold = 1'b0;
      norm_we = 1'b1;
      wait_n(1);
      norm_addr = 4'd15;
      norm_data = 32'h8000_0000;
      wait_n(1);
      norm_addr = 4'd6;
      norm_data = 32'hFFFF_FFFF;
      wait_n(1);
      norm_we = 1'b0;
      hold = 1'b1;
      wait_n(1);
      check("R10 normal load", reg_of(1), 32'hFEED_0001);
      check("R10 normal carry", {31'd0, carry}, 32'd1);
      check("R10 normal field", reg_of(6), 32'hFFF8_0000);
   endtask

   task automatic t_level;
      logic [W-1:0] o;
      shift_word(32'h1111_2222, o);
      addr = 4'd4;
      wait_n(1);
      wr = 1'b1;
      shift_word(32'h3333_4444, o);
      wr = 1'b0;
      wait_n(SETTLE);
      check("R11 single action", reg_of(4), 32'h1111_2222);
      shift_word('0, o);
      check("R11 shift during strobe", o, 32'h3333_4444);
   endtask

   initial begin
      wait_n(5);
      rst_n = 1'b1;
      wait_n(2);
      t_reset();
      t_shift();
      t_write_all();
      t_read();
      t_field();
      t_carry();
      t_unmapped();
      t_both();
      t_lone_a();
      t_hold();
      t_level();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R1..run act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule